// File: doc/BRIEF.md
# Disk Attachment Attention and Command Sequencer

This block is the host-side engine that opens a conversation with a disk attachment. The attachment exposes a small register file: a control register, a status register, an attention register and a 16-bit command interface register. A client hands over one request: an attention code, a device number and, for a command request, a block of two or four 16-bit words. The sequencer then writes the registers in the fixed order the attachment expects. It polls the status bits between steps and reports a single 2-bit result.

Each wait is bounded. The busy-clear wait before the attention write, the per-word wait on the command-full flag and the final completion wait all have cycle limits set by parameters. The completion limit is given in seconds and scaled by a clocks-per-second prescaler, so a test can shrink every limit. An attention that acknowledges a reset-completed interrupt skips the busy wait entirely. A request that carries no command block ends once interrupts are re-enabled.

Top module: `disk_attn_issuer`

## Requirements
- R1: After reset `req_ready` is 1, `done` is 0 and `bus_wr` is 0.
- R2: A command request (`req_is_cmd`=1) that finds status bit 2 (busy) set when it is first examined ends with result 1 (busy) and produces no register write.
- R3: A request's writes come in this order: control register (address 0) with value 0, attention register (address 2), control register with value 1 (interrupt enable), then any command words to address 3.
- R4: The attention write carries the attention code in bits 4:0 and the device number in bits 7:5; bits 15:8 are zero.
- R5: When busy is still set after `ATTN_TRIES` consecutive polls, the request ends with result 2 (attention timeout), and the only write is the control-register mask.
- R6: With `req_rst_ack`=1, the attention write follows the mask write without waiting for busy to clear.
- R7: Command word 0 holds the command code in bits 4:0, the device number in bits 7:5, the options in bits 13:8 (bit 10 is the cache-bypass option) and the length type in bits 15:14.
- R8: With `req_long`=0, two command words are written and the type field is 00. With `req_long`=1, four words are written and the type field is 01. Words 1..3 come from `req_args` slices 0..2.
- R9: Each command word is written only once status bit 1 (command full) is clear. If the flag stays set for `FULL_TRIES` polls, the request ends with result 3 (command timeout).
- R10: After the last word, the request ends with result 0 once status bit 3 (in progress) is clear or status bit 0 (interrupt) is set. If neither happens within `CMD_SECS`×`CLK_PER_SEC` cycles, it ends with result 3.
- R11: `done` is a single-cycle pulse that carries `result`. `req_ready` is 0 from acceptance until the request ends.
- R12: A request with `req_is_cmd`=0 ends with result 0 right after the interrupt-enable write, and never checks busy up front.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_attn | input | CODE_W | Attention code |
| req_dev | input | DEV_W | Device number |
| req_is_cmd | input | 1 | Request carries a command block |
| req_rst_ack | input | 1 | Attention acknowledges a reset-completed interrupt |
| req_long | input | 1 | Four-word block instead of two |
| req_code | input | CODE_W | Command code for word 0 |
| req_opts | input | OPT_W | Option bits for word 0 |
| req_args | input | (MAX_WORDS-1)*WORD_W | Command words 1.. packed from bit 0 |
| done | output | 1 | Request finished (one cycle) |
| result | output | 2 | 0 ok, 1 busy, 2 attention timeout, 3 command timeout |
| bus_wr | output | 1 | Register write strobe |
| bus_addr | output | 2 | 0 control, 1 status, 2 attention, 3 command |
| bus_wdata | output | WORD_W | Register write data |
| att_status | input | 8 | Status bits: 0 interrupt, 1 command full, 2 busy, 3 in progress |

## Verification
The bench targets the edges where each wait gives up or moves on. A busy attachment must reject a command before any write, or the host would clobber a running command. A stuck busy flag must stop the sequence after the mask write and never reach the attention register. The reset-acknowledge path must write the attention register through a busy flag; a design that waited would time out instead. A command-full flag that never clears, and a completion that never comes, must each end in a command timeout. An interrupt that arrives while in-progress is still set must count as completion, or the design would report a false timeout.

// File: rtl/dai_pkg.sv
package dai_pkg;
   typedef enum logic [1:0] {
      RES_OK      = 2'd0,
      RES_BUSY    = 2'd1,
      RES_ATTN_TO = 2'd2,
      RES_CMD_TO  = 2'd3
   } dai_res_e;

   typedef enum logic [1:0] {
      RA_CTRL = 2'd0,
      RA_STAT = 2'd1,
      RA_ATTN = 2'd2,
      RA_CMD  = 2'd3
   } dai_reg_e;

   typedef enum logic [3:0] {
      S_IDLE, S_CHECK, S_MASK, S_WAITB, S_ATTN,
      S_ENA, S_WAITF, S_WORD, S_COMPL
   } dai_state_e;

   localparam int ST_W    = 8;
   localparam int ST_INTR = 0;
   localparam int ST_FULL = 1;
   localparam int ST_BUSY = 2;
   localparam int ST_PROG = 3;

   localparam int TYPE_W = 2;
   localparam logic [TYPE_W-1:0] TYPE_SHORT = 2'b00;
   localparam logic [TYPE_W-1:0] TYPE_LONG  = 2'b01;

   localparam int CTRL_MASKED_VAL = 0;
   localparam int CTRL_IRQ_ON_VAL = 1;
endpackage

// File: rtl/dai_cmd_words.sv
module dai_cmd_words
   import dai_pkg::*;
#(
   parameter int WORD_W      = 16,
   parameter int CODE_W      = 5,
   parameter int DEV_W       = 3,
   parameter int OPT_W       = 6,
   parameter int MAX_WORDS   = 4,
   parameter int SHORT_WORDS = 2
) (
   input  logic [CODE_W-1:0]                  code,
   input  logic [DEV_W-1:0]                   dev,
   input  logic [OPT_W-1:0]                   opts,
   input  logic                               long_fmt,
   input  logic [(MAX_WORDS-1)*WORD_W-1:0]    args,
   output logic [MAX_WORDS-1:0][WORD_W-1:0]   words,
   output logic [$clog2(MAX_WORDS+1)-1:0]     nwords
);
   localparam int NW_W = $clog2(MAX_WORDS+1);

   if (WORD_W != TYPE_W + OPT_W + DEV_W + CODE_W) begin : g_bad_layout
      $error("dai_cmd_words: word 0 fields do not fill WORD_W");
   end
   if (SHORT_WORDS < 1 || SHORT_WORDS > MAX_WORDS) begin : g_bad_short
      $error("dai_cmd_words: SHORT_WORDS out of range");
   end

   assign words[0] = {(long_fmt ? TYPE_LONG : TYPE_SHORT), opts, dev, code};

   for (genvar i = 1; i < MAX_WORDS; i++) begin : g_arg
      assign words[i] = args[(i-1)*WORD_W +: WORD_W];
   end

   assign nwords = long_fmt ? NW_W'(MAX_WORDS) : NW_W'(SHORT_WORDS);
endmodule

// File: rtl/dai_limit_timer.sv
module dai_limit_timer #(
   parameter int unsigned LIMIT    = 16,
   parameter int unsigned PRESCALE = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic hit
);
   localparam int UW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
   localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

   if (LIMIT < 1 || PRESCALE < 1) begin : g_bad_cfg
      $error("dai_limit_timer: LIMIT and PRESCALE must be at least 1");
   end

   if (PRESCALE == 1) begin : g_flat
      logic [UW-1:0] cnt;
      assign hit = en && (cnt == UW'(LIMIT-1));
      always_ff @(posedge clk) begin
         if (!rst_n || clr) cnt <= '0;
         else if (en && !hit) cnt <= cnt + 1'b1;
      end
   end else begin : g_scaled
      logic [PW-1:0] pre;
      logic [UW-1:0] unit;
      logic          tick;
      assign tick = en && (pre == PW'(PRESCALE-1));
      assign hit  = tick && (unit == UW'(LIMIT-1));
      always_ff @(posedge clk) begin
         if (!rst_n || clr) begin
            pre  <= '0;
            unit <= '0;
         end else if (en) begin
            if (tick) begin
               pre <= '0;
               if (!hit) unit <= unit + 1'b1;
            end else begin
               pre <= pre + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/dai_seq.sv
module dai_seq
   import dai_pkg::*;
#(
   parameter int WORD_W    = 16,
   parameter int CODE_W    = 5,
   parameter int DEV_W     = 3,
   parameter int MAX_WORDS = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              req_valid,
   output logic                              req_ready,
   input  logic [CODE_W-1:0]                 req_attn,
   input  logic [DEV_W-1:0]                  req_dev,
   input  logic                              req_is_cmd,
   input  logic                              req_rst_ack,
   input  logic [MAX_WORDS-1:0][WORD_W-1:0]  words,
   input  logic [$clog2(MAX_WORDS+1)-1:0]    nwords,
   input  logic [ST_W-1:0]                   att_status,
   input  logic                              attn_hit,
   input  logic                              full_hit,
   input  logic                              cmp_hit,
   output logic                              attn_en,
   output logic                              attn_clr,
   output logic                              full_en,
   output logic                              full_clr,
   output logic                              cmp_en,
   output logic                              cmp_clr,
   output logic                              done,
   output dai_res_e                          result,
   output logic                              bus_wr,
   output dai_reg_e                          bus_addr,
   output logic [WORD_W-1:0]                 bus_wdata
);
   localparam int IW = $clog2(MAX_WORDS+1);
   localparam int SW = $clog2(MAX_WORDS);
   localparam int AW = CODE_W + DEV_W;

   if (MAX_WORDS < 2) begin : g_bad_words
      $error("dai_seq: MAX_WORDS must be at least 2");
   end
   if (AW > WORD_W) begin : g_bad_attn
      $error("dai_seq: attention byte wider than a word");
   end

   dai_state_e                      state, nxt;
   logic [MAX_WORDS-1:0][WORD_W-1:0] words_q;
   logic [IW-1:0]                   nw_q, idx_q;
   logic [AW-1:0]                   attn_q;
   logic                            is_cmd_q, skip_q;
   logic                            done_q;
   dai_res_e                        res_q;
   logic                            fin;
   dai_res_e                        fin_res;

   logic st_busy, st_full, st_prog, st_intr;
   assign st_busy = att_status[ST_BUSY];
   assign st_full = att_status[ST_FULL];
   assign st_prog = att_status[ST_PROG];
   assign st_intr = att_status[ST_INTR];

   assign req_ready = (state == S_IDLE);
   assign done      = done_q;
   assign result    = res_q;

   always_comb begin
      nxt     = state;
      fin     = 1'b0;
      fin_res = RES_OK;
      case (state)
         S_IDLE:  if (req_valid) nxt = S_CHECK;
         S_CHECK: begin
            if (is_cmd_q && st_busy) begin
               fin     = 1'b1;
               fin_res = RES_BUSY;
            end else begin
               nxt = S_MASK;
            end
         end
         S_MASK:  nxt = skip_q ? S_ATTN : S_WAITB;
         S_WAITB: begin
            if (!st_busy) nxt = S_ATTN;
            else if (attn_hit) begin
               fin     = 1'b1;
               fin_res = RES_ATTN_TO;
            end
         end
         S_ATTN:  nxt = S_ENA;
         S_ENA: begin
            if (is_cmd_q) nxt = S_WAITF;
            else          fin = 1'b1;
         end
         S_WAITF: begin
            if (!st_full) nxt = (idx_q == nw_q) ? S_COMPL : S_WORD;
            else if (full_hit) begin
               fin     = 1'b1;
               fin_res = RES_CMD_TO;
            end
         end
         S_WORD:  nxt = S_WAITF;
         S_COMPL: begin
            if (!st_prog || st_intr) fin = 1'b1;
            else if (cmp_hit) begin
               fin     = 1'b1;
               fin_res = RES_CMD_TO;
            end
         end
         default: nxt = S_IDLE;
      endcase
      if (fin) nxt = S_IDLE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         done_q   <= 1'b0;
         res_q    <= RES_OK;
         idx_q    <= '0;
         nw_q     <= '0;
         words_q  <= '0;
         attn_q   <= '0;
         is_cmd_q <= 1'b0;
         skip_q   <= 1'b0;
      end else begin
         state  <= nxt;
         done_q <= fin;
         if (fin) res_q <= fin_res;
         if (state == S_IDLE && req_valid) begin
            words_q  <= words;
            nw_q     <= nwords;
            attn_q   <= {req_dev, req_attn};
            is_cmd_q <= req_is_cmd;
            skip_q   <= req_rst_ack;
         end
         if (state == S_ENA)  idx_q <= '0;
         if (state == S_WORD) idx_q <= idx_q + 1'b1;
      end
   end

   always_comb begin
      bus_wr    = 1'b0;
      bus_addr  = RA_STAT;
      bus_wdata = '0;
      case (state)
         S_MASK: begin
            bus_wr    = 1'b1;
            bus_addr  = RA_CTRL;
            bus_wdata = WORD_W'(CTRL_MASKED_VAL);
         end
         S_ATTN: begin
            bus_wr    = 1'b1;
            bus_addr  = RA_ATTN;
            bus_wdata = WORD_W'(attn_q);
         end
         S_ENA: begin
            bus_wr    = 1'b1;
            bus_addr  = RA_CTRL;
            bus_wdata = WORD_W'(CTRL_IRQ_ON_VAL);
         end
         S_WORD: begin
            bus_wr    = 1'b1;
            bus_addr  = RA_CMD;
            bus_wdata = words_q[idx_q[SW-1:0]];
         end
         default: ;
      endcase
   end

   assign attn_en  = (state == S_WAITB) && st_busy;
   assign attn_clr = (state != S_WAITB);
   assign full_en  = (state == S_WAITF) && st_full;
   assign full_clr = (state != S_WAITF);
   assign cmp_en   = (state == S_COMPL) && st_prog && !st_intr;
   assign cmp_clr  = (state != S_COMPL);

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2
   busy_reject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && result == RES_BUSY) |-> $past(att_status[ST_BUSY]));

   // R5
   attn_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_ATTN && !skip_q) |-> $past(!att_status[ST_BUSY]));

   // R9
   word_into_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_WORD) |-> $past(!att_status[ST_FULL]));

   // R10
   ok_means_finished_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && result == RES_OK && is_cmd_q) |->
         $past(!att_status[ST_PROG] || att_status[ST_INTR]));
endmodule

// File: rtl/disk_attn_issuer.sv
module disk_attn_issuer
   import dai_pkg::*;
#(
   parameter int          WORD_W      = 16,
   parameter int          CODE_W      = 5,
   parameter int          DEV_W       = 3,
   parameter int          OPT_W       = 6,
   parameter int          MAX_WORDS   = 4,
   parameter int          SHORT_WORDS = 2,
   parameter int unsigned ATTN_TRIES  = 10000,
   parameter int unsigned FULL_TRIES  = 1000,
   parameter int unsigned CMD_SECS    = 15,
   parameter int unsigned CLK_PER_SEC = 250000000
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            req_valid,
   output logic                            req_ready,
   input  logic [CODE_W-1:0]               req_attn,
   input  logic [DEV_W-1:0]                req_dev,
   input  logic                            req_is_cmd,
   input  logic                            req_rst_ack,
   input  logic                            req_long,
   input  logic [CODE_W-1:0]               req_code,
   input  logic [OPT_W-1:0]                req_opts,
   input  logic [(MAX_WORDS-1)*WORD_W-1:0] req_args,
   output logic                            done,
   output logic [1:0]                      result,
   output logic                            bus_wr,
   output logic [1:0]                      bus_addr,
   output logic [WORD_W-1:0]               bus_wdata,
   input  logic [ST_W-1:0]                 att_status
);
   if (WORD_W != TYPE_W + OPT_W + DEV_W + CODE_W) begin : g_bad_word
      $error("disk_attn_issuer: OPT_W must equal WORD_W-TYPE_W-DEV_W-CODE_W");
   end
   if (ATTN_TRIES < 1 || FULL_TRIES < 1 || CMD_SECS < 1) begin : g_bad_lim
      $error("disk_attn_issuer: all limits must be at least 1");
   end

   logic [MAX_WORDS-1:0][WORD_W-1:0] words;
   logic [$clog2(MAX_WORDS+1)-1:0]   nwords;
   logic attn_en, attn_clr, attn_hit;
   logic full_en, full_clr, full_hit;
   logic cmp_en, cmp_clr, cmp_hit;
   dai_res_e res_e;
   dai_reg_e addr_e;

   dai_cmd_words #(
      .WORD_W(WORD_W), .CODE_W(CODE_W), .DEV_W(DEV_W), .OPT_W(OPT_W),
      .MAX_WORDS(MAX_WORDS), .SHORT_WORDS(SHORT_WORDS)
   ) u_words (
      .code(req_code), .dev(req_dev), .opts(req_opts), .long_fmt(req_long),
      .args(req_args), .words(words), .nwords(nwords)
   );

   dai_limit_timer #(.LIMIT(ATTN_TRIES), .PRESCALE(1)) u_attn_tmr (
      .clk(clk), .rst_n(rst_n), .clr(attn_clr), .en(attn_en), .hit(attn_hit)
   );

   dai_limit_timer #(.LIMIT(FULL_TRIES), .PRESCALE(1)) u_full_tmr (
      .clk(clk), .rst_n(rst_n), .clr(full_clr), .en(full_en), .hit(full_hit)
   );

   dai_limit_timer #(.LIMIT(CMD_SECS), .PRESCALE(CLK_PER_SEC)) u_cmp_tmr (
      .clk(clk), .rst_n(rst_n), .clr(cmp_clr), .en(cmp_en), .hit(cmp_hit)
   );

   dai_seq #(
      .WORD_W(WORD_W), .CODE_W(CODE_W), .DEV_W(DEV_W), .MAX_WORDS(MAX_WORDS)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_attn(req_attn), .req_dev(req_dev),
      .req_is_cmd(req_is_cmd), .req_rst_ack(req_rst_ack),
      .words(words), .nwords(nwords), .att_status(att_status),
      .attn_hit(attn_hit), .full_hit(full_hit), .cmp_hit(cmp_hit),
      .attn_en(attn_en), .attn_clr(attn_clr),
      .full_en(full_en), .full_clr(full_clr),
      .cmp_en(cmp_en), .cmp_clr(cmp_clr),
      .done(done), .result(res_e),
      .bus_wr(bus_wr), .bus_addr(addr_e), .bus_wdata(bus_wdata)
   );

   assign result   = res_e;
   assign bus_addr = addr_e;
endmodule

// File: tb/tb_disk_attn_issuer.sv
module tb_disk_attn_issuer;
   import dai_pkg::*;

   localparam int ATT = 8, FT = 6, SECS = 3, CPS = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_ready;
   logic [4:0] req_attn = '0, req_code = '0;
   logic [2:0] req_dev = '0;
   logic req_is_cmd = 1'b0, req_rst_ack = 1'b0, req_long = 1'b0;
   logic [5:0] req_opts = '0;
   logic [47:0] req_args = '0;
   logic done;
   logic [1:0] result;
   logic bus_wr;
   logic [1:0] bus_addr;
   logic [15:0] bus_wdata;
   logic [7:0] att_status;

   int checks = 0, failures = 0, dones = 0, cycles = 0;

   // attachment model state
   int busy_cnt = 0, full_cnt = 0, full_hold = 1, cmp_cnt = 0, cmp_hold = 2, cmp_mode = 0;
   int words_exp = 0, words_seen = 0;
   bit prog = 1'b0, intr = 1'b0, cmd_mode = 1'b0;
   logic [17:0] trace[$];
   logic [1:0]  exp_q[$];
   string       tag_q[$];
   bit          prev_done = 1'b0;

   always #2 clk = ~clk;

   assign att_status = {4'b0, prog, (busy_cnt > 0), (full_cnt > 0), intr};

   disk_attn_issuer #(
      .ATTN_TRIES(ATT), .FULL_TRIES(FT), .CMD_SECS(SECS), .CLK_PER_SEC(CPS)
   ) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_attn(req_attn), .req_dev(req_dev), .req_is_cmd(req_is_cmd),
      .req_rst_ack(req_rst_ack), .req_long(req_long), .req_code(req_code),
      .req_opts(req_opts), .req_args(req_args), .done(done), .result(result),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .att_status(att_status)
   );

   always @(posedge clk) begin
      if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
      if (full_cnt > 0) full_cnt <= full_cnt - 1;
      if (cmp_cnt > 0) begin
         if (cmp_cnt == 1) begin
            if (cmp_mode == 1) intr <= 1'b1;
            else               prog <= 1'b0;
         end
         cmp_cnt <= cmp_cnt - 1;
      end
      if (bus_wr) begin
         trace.push_back({bus_addr, bus_wdata});
         if (bus_addr == RA_ATTN && cmd_mode) prog <= 1'b1;
         if (bus_addr == RA_CMD) begin
            full_cnt   <= full_hold;
            words_seen <= words_seen + 1;
            if (words_seen + 1 == words_exp && cmp_mode != 2) cmp_cnt <= cmp_hold;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         // R11 single-cycle done
         if (done && prev_done) chk(1'b0, "R11", "done wider than one cycle", 1, 0);
         if (done) begin
            if (exp_q.size() == 0) chk(1'b0, "R11", "unexpected done", 1, 0);
            else begin
               logic [1:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(result == e, t, "result", result, e);
            end
            dones++;
         end
      end
      prev_done = done;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         chk(1'b0, "R11", "watchdog expired", cycles, 100000);
         finish_run();
      end
   end

   task automatic model_setup(input int busy, input int fhold, input int cmode,
                              input bit cmd);
      busy_cnt = busy; full_cnt = 0; full_hold = fhold; cmp_cnt = 0;
      cmp_mode = cmode; cmp_hold = 2; prog = 1'b0; intr = 1'b0;
      cmd_mode = cmd; words_seen = 0;
      trace.delete();
   endtask

   task automatic issue(input logic [4:0] attn, input logic [2:0] dev,
                        input bit is_cmd, input bit rst_ack, input bit lng,
                        input logic [4:0] code, input logic [5:0] opts,
                        input logic [15:0] a1, input logic [15:0] a2,
                        input logic [15:0] a3, input logic [1:0] exp_res,
                        input int n_exp, input string tag);
      logic [17:0] exp_w[$];
      int d0;
      exp_w.push_back({RA_CTRL, 16'h0000});
      exp_w.push_back({RA_ATTN, 8'h00, dev, attn});
      exp_w.push_back({RA_CTRL, 16'h0001});
      if (is_cmd) begin
         exp_w.push_back({RA_CMD, (lng ? 2'b01 : 2'b00), opts, dev, code});
         exp_w.push_back({RA_CMD, a1});
         if (lng) begin
            exp_w.push_back({RA_CMD, a2});
            exp_w.push_back({RA_CMD, a3});
         end
      end
      words_exp = lng ? 4 : 2;
      exp_q.push_back(exp_res);
      tag_q.push_back(tag);
      d0 = dones;
      while (!req_ready) @(negedge clk);
      req_attn = attn; req_dev = dev; req_is_cmd = is_cmd; req_rst_ack = rst_ack;
      req_long = lng; req_code = code; req_opts = opts; req_args = {a3, a2, a1};
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      // R11 ready drops after acceptance
      chk(req_ready == 1'b0, "R11", "ready after accept", req_ready, 0);
      while (dones == d0) @(negedge clk);
      chk(trace.size() == n_exp, tag, "write count", trace.size(), n_exp);
      for (int i = 0; i < n_exp && i < trace.size(); i++)
         chk(trace[i] == exp_w[i], tag, "write content", trace[i], exp_w[i]);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(req_ready == 1'b1, "R1", "ready", req_ready, 1);
      chk(done == 1'b0, "R1", "done", done, 0);
      chk(bus_wr == 1'b0, "R1", "bus_wr", bus_wr, 0);

      // R3 R4 R7 short command: opts bit2 = cache bypass (bit 10)
      model_setup(0, 2, 0, 1'b1);
      issue(5'h03, 3'd1, 1'b1, 1'b0, 1'b0, 5'h05, 6'h04, 16'h1234, 16'h0, 16'h0,
            RES_OK, 5, "R3_R4_R7");

      // R8 R9 long command with slow full flag
      model_setup(0, 3, 0, 1'b1);
      issue(5'h03, 3'd7, 1'b1, 1'b0, 1'b1, 5'h01, 6'h2A, 16'hBEEF, 16'h0042, 16'hA5A5,
            RES_OK, 7, "R8_R9");

      // R2 busy reject, no writes
      model_setup(1000, 1, 0, 1'b1);
      issue(5'h03, 3'd0, 1'b1, 1'b0, 1'b0, 5'h02, 6'h00, 16'h0001, 16'h0, 16'h0,
            RES_BUSY, 0, "R2");

      // R5 attention timeout, only mask write
      model_setup(1000, 1, 0, 1'b0);
      issue(5'h04, 3'd2, 1'b0, 1'b0, 1'b0, 5'h00, 6'h00, 16'h0, 16'h0, 16'h0,
            RES_ATTN_TO, 1, "R5");

      // R6 reset acknowledge writes through busy
      model_setup(1000, 1, 0, 1'b0);
      issue(5'h02, 3'd7, 1'b0, 1'b1, 1'b0, 5'h00, 6'h00, 16'h0, 16'h0, 16'h0,
            RES_OK, 3, "R6");

      // R12 attention-only, busy clears within limit
      model_setup(5, 1, 0, 1'b0);
      issue(5'h02, 3'd3, 1'b0, 1'b0, 1'b0, 5'h00, 6'h00, 16'h0, 16'h0, 16'h0,
            RES_OK, 3, "R12");

      // R9 full flag stuck
      model_setup(0, 1000, 0, 1'b1);
      issue(5'h03, 3'd1, 1'b1, 1'b0, 1'b0, 5'h06, 6'h01, 16'h7777, 16'h0, 16'h0,
            RES_CMD_TO, 4, "R9");
      full_cnt = 0;

      // R10 completion never arrives
      model_setup(0, 1, 2, 1'b1);
      issue(5'h03, 3'd0, 1'b1, 1'b0, 1'b0, 5'h07, 6'h00, 16'h0101, 16'h0, 16'h0,
            RES_CMD_TO, 5, "R10");

      // R10 completion by interrupt while still in progress
      model_setup(0, 1, 1, 1'b1);
      issue(5'h03, 3'd1, 1'b1, 1'b0, 1'b1, 5'h08, 6'h10, 16'h0202, 16'h0303, 16'h0404,
            RES_OK, 7, "R10");

      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R11", "pending results", exp_q.size(), 0);
      finish_run();
   end
endmodule